// File: doc/BRIEF.md
# Coherent Split-Measurement Readout Latch

This block keeps four 10-bit measurement results and shows them to software through a byte-wide register read port. The four channels are a supply-rail reading (channel 0), the first remote temperature (channel 1), the local temperature (channel 2) and the second remote temperature (channel 3). The upper eight bits of each result have a register of their own. The two low bits of all four results share one packed register.

A 10-bit value is read in two bus accesses, so a fresh conversion could land between them. Reading the packed register prevents this. It freezes the packed register and all four upper-byte registers. Each upper-byte register is released when it is read. The packed register is released once all four upper-byte registers have been read since the freeze began. Results that arrive during a freeze go into a per-channel shadow copy. Only the newest result is kept, and it appears as soon as the register it belongs to is released.

The read port takes an address and a read strobe and returns data one cycle later. Register addresses are parameters.

Top module: `splitMeasLatch`

## Requirements
- R1: After synchronous active-high reset, every register reads 0x00, no register is frozen, and `rdData` is 0x00.
- R2: `rdData` shows the addressed register one cycle after `rdEn` is sampled high. It keeps its value while `rdEn` is low. A read of an unmapped address returns 0x00.
- R3: When channel i is not frozen, its upper-byte register returns bits [9:2] of the newest result on that channel. Channel i's result arrives on `newData[10*i+9:10*i]` when `newValid[i]` is high.
- R4: The packed register holds the two low bits of each channel: channel 0 in bits [1:0], channel 1 in [3:2], channel 2 in [5:4] and channel 3 in [7:6].
- R5: A read of the packed register freezes it and all four upper-byte registers. While frozen, a register keeps its value even when new results arrive.
- R6: A read of upper-byte register i releases that register. From the next read on, it shows the newest result of channel i.
- R7: The packed register stays frozen until all four upper-byte registers have been read since the freeze. Reading only some of them leaves it frozen.
- R8: If several results arrive on one channel during a freeze, only the last one is shown after release.
- R9: A result that arrives in the same cycle as a packed-register read is not shown by the frozen registers of that freeze.
- R10: A read of the packed register while a freeze is still open freezes all four upper-byte registers again, including any that had already been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| newValid | input | 4 | Per-channel strobe: a new result is present |
| newData | input | 40 | Four 10-bit results, channel i in bits [10*i+9:10*i] |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 8 | Register address for the read |
| rdData | output | 8 | Read data, valid one cycle after the strobe |

## Verification
The assertions assume that the parameter addresses are all different, so no single address selects both the packed register and an upper-byte register. They also assume that reset is held high from time zero until the first clock edge. The stimulus uses only the five default addresses and one unmapped address. Reset is held high from the start. Every input changes on the falling edge, so a strobe is never seen half-changed at a rising edge.

// File: rtl/splitMeasPkg.sv
package splitMeasPkg;
  localparam int NUM_CH = 4;
  localparam int MSB_W  = 8;
  localparam int LSB_W  = 2;
  localparam int MEAS_W = MSB_W + LSB_W;
  localparam int PACK_W = NUM_CH * LSB_W;

  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic              rdAny;
    logic              rdLsb;
    logic [NUM_CH-1:0] rdMsb;
    logic [NUM_CH-1:0] loadMsb;
    logic              loadLsb;
  } ctlStrobeT;
endpackage

// File: rtl/splitMeasCtl.sv
module splitMeasCtl
  import splitMeasPkg::*;
#(
  parameter int                       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]        LSB_ADDR  = 8'h14,
  parameter logic [NUM_CH*ADDR_W-1:0] MSB_ADDRS = {8'h13, 8'h12, 8'h11, 8'h10}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctlStrobeT         strb,
  output logic [NUM_CH-1:0] msbFrz,
  output logic              lsbFrz
);
  logic [NUM_CH-1:0] msbHit;
  logic [NUM_CH-1:0] msbFrzNext;
  logic              lsbHit;
  logic              lsbFrzNext;

  assign lsbHit = rdEn && (rdAddr == LSB_ADDR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign msbHit[c] = rdEn && (rdAddr == MSB_ADDRS[c*ADDR_W +: ADDR_W]);
    // packed read arms every channel; own read disarms it
    assign msbFrzNext[c] = lsbHit | (msbFrz[c] & ~msbHit[c]);
  end

  // packed register opens only when every upper byte has been drained
  assign lsbFrzNext = lsbHit | (lsbFrz & (|msbFrzNext));

  always_comb begin
    strb.rdAny   = rdEn;
    strb.rdLsb   = lsbHit;
    strb.rdMsb   = msbHit;
    strb.loadMsb = ~msbFrzNext;
    strb.loadLsb = ~lsbFrzNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msbFrz <= '0;
      lsbFrz <= 1'b0;
    end else begin
      msbFrz <= msbFrzNext;
      lsbFrz <= lsbFrzNext;
    end
  end
endmodule

// File: rtl/splitMeasDp.sv
module splitMeasDp
  import splitMeasPkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        newValid,
  input  logic [NUM_CH*MEAS_W-1:0] newData,
  input  ctlStrobeT                strb,
  output logic [MSB_W-1:0]         rdData
);
  logic [MEAS_W-1:0] shadow     [NUM_CH];
  logic [MEAS_W-1:0] shadowNext [NUM_CH];
  logic [MSB_W-1:0]  msbReg     [NUM_CH];
  logic [LSB_W-1:0]  lsbReg     [NUM_CH];
  logic [PACK_W-1:0] packedLsb;
  logic [MSB_W-1:0]  msbSel;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign shadowNext[c] = newValid[c] ? newData[c*MEAS_W +: MEAS_W] : shadow[c];
    assign packedLsb[c*LSB_W +: LSB_W] = lsbReg[c];

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[c] <= '0;
        msbReg[c] <= '0;
        lsbReg[c] <= '0;
      end else begin
        shadow[c] <= shadowNext[c];
        if (strb.loadMsb[c]) msbReg[c] <= shadowNext[c][MEAS_W-1:LSB_W];
        if (strb.loadLsb)    lsbReg[c] <= shadowNext[c][LSB_W-1:0];
      end
    end
  end

  always_comb begin
    msbSel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strb.rdMsb[c]) msbSel = msbSel | msbReg[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdAny) begin
      rdData <= strb.rdLsb ? packedLsb : msbSel;
    end
  end
endmodule

// File: rtl/splitMeasLatch.sv
module splitMeasLatch
  import splitMeasPkg::*;
#(
  parameter int                       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]        LSB_ADDR  = 8'h14,
  parameter logic [NUM_CH*ADDR_W-1:0] MSB_ADDRS = {8'h13, 8'h12, 8'h11, 8'h10}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        newValid,
  input  logic [NUM_CH*MEAS_W-1:0] newData,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [MSB_W-1:0]         rdData
);
  ctlStrobeT         strb;
  logic [NUM_CH-1:0] msbFrz;
  logic              lsbFrz;

  splitMeasCtl #(
    .ADDR_W   (ADDR_W),
    .LSB_ADDR (LSB_ADDR),
    .MSB_ADDRS(MSB_ADDRS)
  ) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .rdEn  (rdEn),
    .rdAddr(rdAddr),
    .strb  (strb),
    .msbFrz(msbFrz),
    .lsbFrz(lsbFrz)
  );

  splitMeasDp u_dp (
    .clk     (clk),
    .rst     (rst),
    .newValid(newValid),
    .newData (newData),
    .strb    (strb),
    .rdData  (rdData)
  );
endmodule

// File: rtl/splitMeasChk.sv
module splitMeasChk
  import splitMeasPkg::*;
#(
  parameter int                       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]        LSB_ADDR  = 8'h14,
  parameter logic [NUM_CH*ADDR_W-1:0] MSB_ADDRS = {8'h13, 8'h12, 8'h11, 8'h10}
) (
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [MSB_W-1:0]  rdData,
  input logic [NUM_CH-1:0] msbFrz,
  input logic              lsbFrz
);
  // R1: state right after reset is clear
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lsbFrz && msbFrz == '0 && rdData == '0));

  // R2: output holds when no read strobe
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

  // R5: packed read freezes everything
  p_lsb_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr == LSB_ADDR) |=> (lsbFrz && (&msbFrz)));

  // R7: packed register never open-frozen without a pending upper byte
  p_lsb_pending_r7: assert property (@(posedge clk) disable iff (rst)
    lsbFrz |-> (|msbFrz));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6: own read releases the upper byte
    p_msb_release_r6: assert property (@(posedge clk) disable iff (rst)
      (rdEn && rdAddr == MSB_ADDRS[c*ADDR_W +: ADDR_W]) |=> !msbFrz[c]);
  end
endmodule

bind splitMeasLatch splitMeasChk #(
  .ADDR_W   (ADDR_W),
  .LSB_ADDR (LSB_ADDR),
  .MSB_ADDRS(MSB_ADDRS)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .rdEn  (rdEn),
  .rdAddr(rdAddr),
  .rdData(rdData),
  .msbFrz(msbFrz),
  .lsbFrz(lsbFrz)
);

// File: tb/splitMeasLatch_tb.sv
module splitMeasLatch_tb;
  localparam logic [7:0] A_LSB = 8'h14;
  localparam logic [7:0] A_M0  = 8'h10;
  localparam logic [7:0] A_M1  = 8'h11;
  localparam logic [7:0] A_M2  = 8'h12;
  localparam logic [7:0] A_M3  = 8'h13;
  localparam logic [7:0] A_BAD = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  newValid = '0;
  logic [39:0] newData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [7:0]  rdData;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] lastExp = '0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  splitMeasLatch u_dut (
    .clk(clk), .rst(rst), .newValid(newValid), .newData(newData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [7:0] pk(logic [1:0] a, logic [1:0] b, logic [1:0] c, logic [1:0] d);
    return {d, c, b, a};
  endfunction

  task automatic doRead(logic [7:0] addr, logic [7:0] exp, string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    lastExp = exp;
    rdEn = 1'b1;
    rdAddr = addr;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readWithPush(logic [7:0] addr, logic [7:0] exp, string tag,
                              int ch, logic [9:0] v);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    lastExp = exp;
    rdEn = 1'b1;
    rdAddr = addr;
    newValid[ch] = 1'b1;
    newData[ch*10 +: 10] = v;
    @(negedge clk);
    rdEn = 1'b0;
    newValid = '0;
  endtask

  task automatic pushAll(logic [9:0] v0, logic [9:0] v1, logic [9:0] v2, logic [9:0] v3);
    @(negedge clk);
    newValid = 4'hF;
    newData = {v3, v2, v1, v0};
    @(negedge clk);
    newValid = '0;
  endtask

  task automatic pushOne(int ch, logic [9:0] v);
    @(negedge clk);
    newValid[ch] = 1'b1;
    newData[ch*10 +: 10] = v;
    @(negedge clk);
    newValid = '0;
  endtask

  task automatic checkHold(string tag);
    @(negedge clk);
    nChecks++;
    if (rdData !== lastExp) begin
      nFails++;
      $display("FAIL %s: rdData=%h expected %h", tag, rdData, lastExp);
    end
  endtask

  // monitor: scoreboard pop on the cycle after each sampled strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn && !rst) begin
        @(negedge clk);
        if (expQ.size() > 0) begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          nChecks++;
          if (rdData !== e) begin
            nFails++;
            $display("FAIL %s: rdData=%h expected %h", t, rdData, e);
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nChecks++;
    if (rdData !== 8'h00) begin
      nFails++;
      $display("FAIL R1: rdData=%h expected 00", rdData);
    end
    // R1: all registers zero after reset
    doRead(A_LSB, 8'h00, "R1 packed");
    doRead(A_M0, 8'h00, "R1 msb0");
    doRead(A_M1, 8'h00, "R1 msb1");
    doRead(A_M2, 8'h00, "R1 msb2");
    doRead(A_M3, 8'h00, "R1 msb3");
    // R2: unmapped address, then hold
    doRead(A_BAD, 8'h00, "R2 unmapped");
    doRead(A_M0, 8'h00, "R2 mapped");
    // batch A
    pushAll(10'h2D7, 10'h1A2, 10'h0F5, 10'h300);
    doRead(A_M0, 8'hB5, "R3 msb0");
    checkHold("R2 hold");
    doRead(A_M1, 8'h68, "R3 msb1");
    doRead(A_M2, 8'h3D, "R3 msb2");
    doRead(A_M3, 8'hC0, "R3 msb3");
    doRead(A_LSB, pk(2'd3, 2'd2, 2'd1, 2'd0), "R4 packed layout");
    // frozen now: batch B arrives
    pushAll(10'h155, 10'h0AA, 10'h26F, 10'h3C5);
    doRead(A_M0, 8'hB5, "R5 msb0 frozen");
    doRead(A_M0, 8'h55, "R6 msb0 released");
    doRead(A_M1, 8'h68, "R5 msb1 frozen");
    doRead(A_M2, 8'h3D, "R5 msb2 frozen");
    doRead(A_LSB, pk(2'd3, 2'd2, 2'd1, 2'd0), "R7 packed still frozen");
    // re-armed freeze
    pushOne(0, 10'h3FF);
    doRead(A_M0, 8'h55, "R10 msb0 refrozen");
    doRead(A_M1, 8'h2A, "R10 msb1 refrozen");
    doRead(A_M2, 8'h9B, "R10 msb2 refrozen");
    doRead(A_M3, 8'hC0, "R5 msb3 long frozen");
    doRead(A_LSB, pk(2'd3, 2'd2, 2'd3, 2'd1), "R8 packed newest");
    doRead(A_M3, 8'hF1, "R6 msb3");
    doRead(A_M0, 8'hFF, "R8 msb0 newest");
    doRead(A_M1, 8'h2A, "R6 msb1");
    doRead(A_M2, 8'h9B, "R6 msb2");
    // same-cycle arrival during packed read
    readWithPush(A_LSB, pk(2'd3, 2'd2, 2'd3, 2'd1), "R9 packed", 2, 10'h001);
    doRead(A_M2, 8'h9B, "R9 msb2 old");
    doRead(A_M2, 8'h00, "R9 msb2 new");
    doRead(A_M0, 8'hFF, "R6 msb0");
    doRead(A_M1, 8'h2A, "R6 msb1");
    doRead(A_M3, 8'hF1, "R6 msb3");
    doRead(A_LSB, pk(2'd3, 2'd2, 2'd1, 2'd1), "R4 packed after update");
    doRead(A_M0, 8'hFF, "R3 msb0");
    doRead(A_M1, 8'h2A, "R3 msb1");
    doRead(A_M2, 8'h00, "R3 msb2");
    doRead(A_M3, 8'hF1, "R3 msb3");
    checkHold("R2 hold end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule